// File: doc/BRIEF.md
# Flash Read Line Buffer with Next-Line Fetch

This block is a read front end for a non-volatile memory array. It faces a 64-bit system read port on one side and a 128-bit array read port on the other, so one array line carries two bus words. It keeps four line buffers. A read whose line is already buffered is answered in the same cycle. A read that misses holds the bus off for a programmable number of wait states while the whole line is fetched. The line is stored and the requested half goes back to the requester.

The wait-state count follows the clock rate the system runs at. One wait state suits the slowest clock, two the middle one and three the fastest. After a demand fill the block can optionally fetch the following line in the background. It does this only in cycles when no read is pending, and it skips the fetch when that line is already held. Software or a neighbouring controller must pulse the flush input whenever the array contents change.

The bus handshake is plain: the requester raises `rd_req` with a byte address and holds both until `rd_ready` is seen high. The array port presents a line address while `arr_req` is high. It must return that line on `arr_rdata` once the latched number of wait-state cycles has elapsed.

Top module: `flash_line_prefetcher`

## Requirements
- R1: A read whose line is held in a valid buffer sees `rd_ready` high in the same cycle `rd_req` is raised (zero wait states), provided no array access is in progress.
- R2: A read that misses sees `rd_ready` low for exactly N cycles and high in the next one. N is the value of `wait_cfg` (1, 2 or 3) sampled when the access starts, and a value of 0 is treated as 1. The returned word comes from the freshly fetched line.
- R3: Address bit 3 picks the half of the line: 0 returns line bits [63:0] and 1 returns line bits [127:64]. Address bits [2:0] have no effect on the result.
- R4: The buffer tag is address bits [23:4]. A hit needs a valid buffer whose tag equals those bits exactly, so two addresses that differ in any of those bits never share a buffer.
- R5: Stored fills go into the buffers in rotating order 0, 1, 2, 3, 0, … so a fifth distinct line evicts the first one filled.
- R6: With `nextline_en` high, a stored demand fill of line L schedules line L+1. That fetch starts in the first later cycle with `rd_req` low, and it is skipped without any array access if L+1 is already buffered.
- R7: During an array access `arr_req` stays high and `arr_line` stays constant. A read arriving meanwhile is held with `rd_ready` low until the access completes.
- R8: A `flush_bufs` pulse clears every valid bit from the next cycle on and cancels any scheduled next-line fetch. A fill whose access saw a flush in any of its cycles is not stored, but the demand data is still returned.
- R9: Changing `wait_cfg` while an access is in progress does not change the length of that access.
- R10: With `nextline_en` low the array is accessed only for demand misses.
- R11: After reset no buffer is valid, `arr_req` is low and the first read of any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | 24 | Byte address of the read |
| rd_ready | output | 1 | Read completes in this cycle |
| rd_data | output | 64 | Read data, valid while `rd_ready` is high |
| wait_cfg | input | 2 | Wait states per array access (0 behaves as 1) |
| nextline_en | input | 1 | Enables background fetch of the next line |
| flush_bufs | input | 1 | Invalidates all buffers |
| arr_req | output | 1 | Array access in progress |
| arr_line | output | 20 | Line address presented to the array |
| arr_rdata | input | 128 | Line returned by the array |

## Verification
The bench targets several error-prone cases. The wait-state setting changes in the middle of an access; a design that read it live would answer early. A flush lands inside a fill; a design that kept the stale line would hit on the next read. Five distinct lines are read so that the rotating replacement is observed; a wrong pointer evicts a line that should still hit. The background fetch is tested three ways: once in a plain idle window, once when the next line is already held, and once when a read of either the fetching line or an unrelated line arrives mid-fetch. A design that fetched twice, fetched with the feature off, or released the bus early would show extra or missing `arr_req` cycles and wrong wait counts.

// File: rtl/fpb_pkg.sv
// Package: shared types of the flash line-buffer read front end.
// Assumes: nothing beyond IEEE 1800-2017.
package fpb_pkg;

    // Access sequencer state: idle (hits served) or array access running.
    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACCESS = 1'b1
    } seq_state_e;

    // Purpose of the array access in flight.
    typedef enum logic {
        FILL_NEXTLINE = 1'b0,
        FILL_DEMAND   = 1'b1
    } fill_kind_e;

endpackage

// File: rtl/fpb_line_store.sv
// Module: fpb_line_store
// Holds NUM_BUF line buffers with tag and valid bit each. Two lookup ports
// (bus address and scheduled next line) and one write port, which fills
// buffers in rotating order. A flush clears every valid bit.
// Assumes: a tag is never stored twice (callers write only on a miss), so
// at most one buffer matches and the read mux may OR masked entries.
module fpb_line_store #(
    parameter int NUM_BUF = 4,
    parameter int TAG_W   = 20,
    parameter int LINE_W  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   look_tag,
    output logic               look_hit,
    output logic [LINE_W-1:0]  look_data,
    input  logic [TAG_W-1:0]   probe_tag,
    output logic               probe_hit,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [LINE_W-1:0]  wr_data,
    output logic [NUM_BUF-1:0] valid_vec
);
    localparam int IDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

    logic [IDX_W-1:0]   victim_q;
    logic [NUM_BUF-1:0] look_match;
    logic [NUM_BUF-1:0] probe_match;
    logic [LINE_W-1:0]  masked_data [NUM_BUF];

    // Replacement pointer: advance past each buffer as it is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_q <= '0;
        end else if (wr_en) begin
            victim_q <= (victim_q == LAST_IDX) ? '0 : victim_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        logic              vld_q;
        logic [TAG_W-1:0]  tag_q;
        logic [LINE_W-1:0] line_q;
        logic              sel_w;

        assign sel_w = wr_en && (victim_q == IDX_W'(g));

        // Valid bit: cleared by reset or flush, set when this buffer is filled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (flush) begin
                vld_q <= 1'b0;
            end else if (sel_w) begin
                vld_q <= 1'b1;
            end
        end

        // Tag register: loaded with the line address on a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
            end else if (sel_w) begin
                tag_q <= wr_tag;
            end
        end

        // Line data: loaded on a fill, no reset needed (guarded by valid).
        always_ff @(posedge clk) begin
            if (sel_w) begin
                line_q <= wr_data;
            end
        end

        assign valid_vec[g]   = vld_q;
        assign look_match[g]  = vld_q && (tag_q == look_tag);
        assign probe_match[g] = vld_q && (tag_q == probe_tag);
        assign masked_data[g] = look_match[g] ? line_q : '0;
    end

    // Read mux: OR of masked entries, valid because matches are one-hot.
    always_comb begin
        look_data = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            look_data = look_data | masked_data[i];
        end
    end

    assign look_hit  = |look_match;
    assign probe_hit = |probe_match;

endmodule

// File: rtl/fpb_access_seq.sv
// Module: fpb_access_seq
// Runs array accesses: starts a demand access on a bus miss, or a next-line
// access when the bus is quiet and one is scheduled. Latches the wait-state
// count at start, counts it down, and tells the store whether to keep the fill.
// Assumes: the requester holds the request and address stable until ready.
module fpb_access_seq
    import fpb_pkg::*;
#(
    parameter int TAG_W = 20,
    parameter int WS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic [TAG_W-1:0] bus_tag,
    input  logic             bus_hit,
    input  logic             next_en,
    input  logic             pend_hit,
    input  logic             flush,
    input  logic [WS_W-1:0]  ws_cfg,
    output logic             idle,
    output logic             acc_active,
    output logic [TAG_W-1:0] acc_tag,
    output logic             acc_done,
    output logic             acc_demand,
    output logic             fill_store,
    output logic [TAG_W-1:0] pend_tag,
    output logic [WS_W-1:0]  ws_lat
);
    localparam logic [WS_W-1:0] WS_MIN = WS_W'(1);

    seq_state_e       state_q;
    fill_kind_e       kind_q;
    logic [WS_W-1:0]  cnt_q;
    logic [WS_W-1:0]  ws_lat_q;
    logic [TAG_W-1:0] line_q;
    logic             drop_q;
    logic             pend_q;
    logic [TAG_W-1:0] pend_q_tag;
    logic [WS_W-1:0]  ws_eff;
    logic             start_demand;
    logic             pf_try;
    logic             start_next;

    assign idle         = (state_q == SEQ_IDLE);
    assign acc_active   = (state_q == SEQ_ACCESS);
    assign ws_eff       = (ws_cfg == '0) ? WS_MIN : ws_cfg;
    assign start_demand = idle && bus_req && !bus_hit;
    assign pf_try       = idle && !bus_req && pend_q && next_en;
    assign start_next   = pf_try && !pend_hit;
    assign acc_done     = acc_active && (cnt_q == ws_lat_q);
    assign fill_store   = acc_done && !(drop_q || flush);
    assign acc_demand   = (kind_q == FILL_DEMAND);
    assign acc_tag      = line_q;
    assign pend_tag     = pend_q_tag;
    assign ws_lat       = ws_lat_q;

    // State register: enter access on any start, leave when the count is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (start_demand || start_next) begin
            state_q <= SEQ_ACCESS;
        end else if (acc_done) begin
            state_q <= SEQ_IDLE;
        end
    end

    // Access context: line, kind and latched wait count, captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= '0;
            kind_q   <= FILL_DEMAND;
            ws_lat_q <= WS_MIN;
        end else if (start_demand) begin
            line_q   <= bus_tag;
            kind_q   <= FILL_DEMAND;
            ws_lat_q <= ws_eff;
        end else if (start_next) begin
            line_q   <= pend_q_tag;
            kind_q   <= FILL_NEXTLINE;
            ws_lat_q <= ws_eff;
        end
    end

    // Cycle counter: 1 in the first access cycle, steps until the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_demand || start_next) begin
            cnt_q <= WS_MIN;
        end else if (acc_active && !acc_done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Drop flag: remembers a flush seen during the access so the fill is discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (start_demand || start_next) begin
            drop_q <= flush;
        end else if (acc_active && !acc_done) begin
            drop_q <= drop_q || flush;
        end
    end

    // Next-line schedule: set by a kept demand fill, cleared when tried or cancelled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_q_tag <= '0;
        end else if (flush || !next_en) begin
            pend_q <= 1'b0;
        end else if (fill_store && acc_demand) begin
            pend_q     <= 1'b1;
            pend_q_tag <= line_q + 1'b1;
        end else if (pf_try) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_line_prefetcher.sv
// Module: flash_line_prefetcher (top)
// Read front end between a BUS_W-bit system read port and a 2*BUS_W-bit
// array line port. Hits are answered combinationally from the line store;
// misses wait for the sequencer, whose array data is forwarded to the bus
// in the completing cycle while it is written into the store.
// Assumes: the array returns arr_rdata for arr_line once the latched number
// of access cycles has elapsed; bus address is stable while rd_req is high.
module flash_line_prefetcher #(
    parameter int ADDR_W  = 24,
    parameter int BUS_W   = 64,
    parameter int NUM_BUF = 4,
    parameter int WS_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_req,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic                               rd_ready,
    output logic [BUS_W-1:0]                   rd_data,
    input  logic [WS_W-1:0]                    wait_cfg,
    input  logic                               nextline_en,
    input  logic                               flush_bufs,
    output logic                               arr_req,
    output logic [ADDR_W-$clog2(BUS_W/8)-2:0]  arr_line,
    input  logic [2*BUS_W-1:0]                 arr_rdata
);
    localparam int LINE_W = 2 * BUS_W;
    localparam int OFF_W  = $clog2(BUS_W / 8);
    localparam int HALF_B = OFF_W;
    localparam int TAG_W  = ADDR_W - OFF_W - 1;

    logic [TAG_W-1:0]   bus_tag;
    logic               half_sel;
    logic               bus_hit;
    logic [LINE_W-1:0]  hit_line;
    logic [TAG_W-1:0]   pend_tag;
    logic               pend_hit;
    logic               seq_idle;
    logic               acc_active;
    logic [TAG_W-1:0]   acc_tag;
    logic               acc_done;
    logic               acc_demand;
    logic               fill_store;
    logic [WS_W-1:0]    ws_lat;
    logic [NUM_BUF-1:0] valid_vec;
    logic [LINE_W-1:0]  src_line;

    assign bus_tag  = rd_addr[ADDR_W-1:HALF_B+1];
    assign half_sel = rd_addr[HALF_B];

    fpb_line_store #(
        .NUM_BUF (NUM_BUF),
        .TAG_W   (TAG_W),
        .LINE_W  (LINE_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_tag  (bus_tag),
        .look_hit  (bus_hit),
        .look_data (hit_line),
        .probe_tag (pend_tag),
        .probe_hit (pend_hit),
        .flush     (flush_bufs),
        .wr_en     (fill_store),
        .wr_tag    (acc_tag),
        .wr_data   (arr_rdata),
        .valid_vec (valid_vec)
    );

    fpb_access_seq #(
        .TAG_W (TAG_W),
        .WS_W  (WS_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (rd_req),
        .bus_tag    (bus_tag),
        .bus_hit    (bus_hit),
        .next_en    (nextline_en),
        .pend_hit   (pend_hit),
        .flush      (flush_bufs),
        .ws_cfg     (wait_cfg),
        .idle       (seq_idle),
        .acc_active (acc_active),
        .acc_tag    (acc_tag),
        .acc_done   (acc_done),
        .acc_demand (acc_demand),
        .fill_store (fill_store),
        .pend_tag   (pend_tag),
        .ws_lat     (ws_lat)
    );

    // Bus response: hit while idle, or the completing demand access.
    always_comb begin
        rd_ready = (seq_idle && rd_req && bus_hit) || (acc_done && acc_demand);
        src_line = seq_idle ? hit_line : arr_rdata;
        rd_data  = half_sel ? src_line[LINE_W-1:BUS_W] : src_line[BUS_W-1:0];
    end

    assign arr_req  = acc_active;
    assign arr_line = acc_tag;

endmodule

// File: rtl/fpb_checker.sv
// Module: fpb_checker
// Temporal checks on the line-buffer read front end, bound into the top.
// Assumes: the bound instance's internal names bus_hit, ws_lat, valid_vec.
module fpb_checker #(
    parameter int TAG_W   = 20,
    parameter int WS_W    = 2,
    parameter int NUM_BUF = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_req,
    input logic               rd_ready,
    input logic               arr_req,
    input logic [TAG_W-1:0]   arr_line,
    input logic               flush_bufs,
    input logic               nextline_en,
    input logic               bus_hit,
    input logic [WS_W-1:0]    ws_lat,
    input logic [NUM_BUF-1:0] valid_vec
);
    // R1: a held line with no access in flight answers at once.
    assert_hit_zero_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_hit && !arr_req) |-> rd_ready);

    // R2: the latched wait count is never zero during an access.
    assert_wait_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> (ws_lat != '0));

    // R7: line address stays put across consecutive access cycles.
    assert_line_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && $past(arr_req)) |-> (arr_line == $past(arr_line)));

    // R8: a flush leaves no valid buffer in the following cycle.
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_bufs |=> (valid_vec == '0));

    // R9: the wait count is frozen while an access runs.
    assert_wait_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && $past(arr_req)) |-> (ws_lat == $past(ws_lat)));

    // R10: with next-line fetch off, an access begins only for a pending read.
    assert_demand_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arr_req) && !$past(nextline_en)) |-> $past(rd_req));

    // R11: leaving reset, no access and no answer.
    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!arr_req && !rd_ready));

endmodule

bind flash_line_prefetcher fpb_checker #(
    .TAG_W   (TAG_W),
    .WS_W    (WS_W),
    .NUM_BUF (NUM_BUF)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .rd_ready    (rd_ready),
    .arr_req     (arr_req),
    .arr_line    (arr_line),
    .flush_bufs  (flush_bufs),
    .nextline_en (nextline_en),
    .bus_hit     (bus_hit),
    .ws_lat      (ws_lat),
    .valid_vec   (valid_vec)
);

// File: tb/flash_line_prefetcher_tb_top.sv
// Bench: behavioural reference model of the line-buffer read front end,
// compared against the design every cycle, plus directed latency checks.
module flash_line_prefetcher_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rd_req;
    logic [23:0]  rd_addr;
    logic         rd_ready;
    logic [63:0]  rd_data;
    logic [1:0]   wait_cfg;
    logic         nextline_en;
    logic         flush_bufs;
    logic         arr_req;
    logic [19:0]  arr_line;
    logic [127:0] arr_rdata;

    always #5 clk = ~clk;

    // Array content: a fixed function of the line address.
    function automatic logic [127:0] line_word(input logic [19:0] t);
        logic [31:0] x;
        x = {12'h000, t};
        return {x ^ 32'hA5C3_0000, ~x, x * 32'd7 + 32'd11, 32'h1234_0000 + x};
    endfunction

    assign arr_rdata = line_word(arr_line);

    flash_line_prefetcher dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .wait_cfg    (wait_cfg),
        .nextline_en (nextline_en),
        .flush_bufs  (flush_bufs),
        .arr_req     (arr_req),
        .arr_line    (arr_line),
        .arr_rdata   (arr_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Reference model state
    int          m_busy;
    int          m_cnt;
    int          m_wsl;
    bit          m_dem;
    bit          m_drop;
    logic [19:0] m_line;
    bit          m_pend;
    logic [19:0] m_pline;
    logic [19:0] m_tag [4];
    bit          m_val [4];
    int          m_rr;

    logic        obs_ready;
    logic [63:0] obs_data;
    logic        obs_areq;

    function automatic int m_find(input logic [19:0] t);
        for (int i = 0; i < 4; i++) begin
            if (m_val[i] && m_tag[i] == t) return i;
        end
        return -1;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One clock: compare outputs mid-cycle, then advance the model at the edge.
    task automatic step();
        logic         e_ready;
        logic [63:0]  e_data;
        logic [127:0] ln;
        logic [19:0]  rtag;
        int           hi;
        int           wse;
        bit           fl;
        #1;
        rtag    = rd_addr[23:4];
        e_ready = 1'b0;
        e_data  = '0;
        ln      = '0;
        if (m_busy == 0) begin
            if (rd_req && m_find(rtag) >= 0) begin
                e_ready = 1'b1;
                ln      = line_word(rtag);
            end
        end else if (m_dem && m_cnt == m_wsl) begin
            e_ready = 1'b1;
            ln      = line_word(m_line);
        end
        e_data    = rd_addr[3] ? ln[127:64] : ln[63:0];
        obs_ready = rd_ready;
        obs_data  = rd_data;
        obs_areq  = arr_req;
        if (rst_n) begin
            checks++;
            if (arr_req !== (m_busy == 1) || (m_busy == 1 && arr_line !== m_line)) begin
                fails++;
                $display("FAIL R7: arr_req=%0b arr_line=%h expected %0b/%h",
                         arr_req, arr_line, (m_busy == 1), m_line);
            end else if (rd_ready !== e_ready || (e_ready && rd_data !== e_data)) begin
                fails++;
                $display("FAIL %s: ready=%0b data=%h expected %0b/%h",
                         (m_busy == 0) ? "R1" : "R2", rd_ready, rd_data, e_ready, e_data);
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_wsl = 1; m_dem = 1'b1; m_drop = 1'b0;
            m_line = '0; m_pend = 1'b0; m_pline = '0; m_rr = 0;
            for (int i = 0; i < 4; i++) begin
                m_val[i] = 1'b0;
                m_tag[i] = '0;
            end
        end else begin
            fl  = flush_bufs;
            wse = (wait_cfg == 2'd0) ? 1 : int'(wait_cfg);
            hi  = m_find(rtag);
            if (m_busy == 0) begin
                if (rd_req && hi < 0) begin
                    m_busy = 1; m_line = rtag; m_cnt = 1; m_wsl = wse;
                    m_dem = 1'b1; m_drop = fl;
                end else if (!rd_req && m_pend && nextline_en) begin
                    if (m_find(m_pline) < 0) begin
                        m_busy = 1; m_line = m_pline; m_cnt = 1; m_wsl = wse;
                        m_dem = 1'b0; m_drop = fl;
                    end
                    m_pend = 1'b0;
                end
            end else begin
                if (m_cnt == m_wsl) begin
                    if (!(m_drop || fl)) begin
                        m_tag[m_rr] = m_line;
                        m_val[m_rr] = 1'b1;
                        m_rr = (m_rr + 1) % 4;
                        if (m_dem && nextline_en) begin
                            m_pend  = 1'b1;
                            m_pline = m_line + 20'd1;
                        end
                    end
                    m_busy = 0;
                end else begin
                    m_cnt++;
                    m_drop = m_drop || fl;
                end
            end
            if (fl) begin
                for (int i = 0; i < 4; i++) m_val[i] = 1'b0;
                m_pend = 1'b0;
            end
            if (!nextline_en) m_pend = 1'b0;
        end
        @(negedge clk);
    endtask

    // Bus read; optionally change wait_cfg and/or pulse flush at cycle mod_at.
    task automatic do_read(input logic [23:0] a, input int mod_at,
                           input logic [1:0] mod_ws, input bit mod_fl,
                           output int waits);
        int           k;
        logic [127:0] ln;
        k       = 0;
        waits   = 0;
        rd_req  = 1'b1;
        rd_addr = a;
        forever begin
            if (k == mod_at) begin
                wait_cfg   = mod_ws;
                flush_bufs = mod_fl;
            end else begin
                flush_bufs = 1'b0;
            end
            step();
            k++;
            if (obs_ready) break;
            waits++;
            if (waits > 40) break;
        end
        rd_req     = 1'b0;
        flush_bufs = 1'b0;
        ln = line_word(a[23:4]);
        checks++;
        if (obs_data !== (a[3] ? ln[127:64] : ln[63:0])) begin
            fails++;
            $display("FAIL R3: data=%h expected %h at %h", obs_data,
                     (a[3] ? ln[127:64] : ln[63:0]), a);
        end
    endtask

    task automatic rd(input logic [23:0] a, output int waits);
        do_read(a, -1, 2'd0, 1'b0, waits);
    endtask

    task automatic idle_cycles(input int n, output int busy);
        busy   = 0;
        rd_req = 1'b0;
        repeat (n) begin
            step();
            if (obs_areq) busy++;
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int w;
        int b;
        rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0; wait_cfg = 2'd2;
        nextline_en = 1'b0; flush_bufs = 1'b0;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;

        // R11: quiet after reset, first read misses
        idle_cycles(1, b);
        chk("R11 no access after reset", b, 0);
        chk("R11 no ready after reset", int'(obs_ready), 0);
        rd(24'h000100, w);  chk("R11 first read misses (R2 ws=2)", w, 2);

        // R1, R3: other half hits with zero waits, low bits ignored
        rd(24'h000108, w);  chk("R1 hit upper half", w, 0);
        rd(24'h00010C, w);  chk("R3 low bits ignored", w, 0);
        rd(24'h000103, w);  chk("R3 lower half hit", w, 0);

        // R2: each wait-state setting, 0 behaves as 1
        wait_cfg = 2'd1; rd(24'h000200, w); chk("R2 ws=1", w, 1);
        wait_cfg = 2'd3; rd(24'h000300, w); chk("R2 ws=3", w, 3);
        wait_cfg = 2'd0; rd(24'h000400, w); chk("R2 ws=0 as 1", w, 1);

        // R5: fifth line evicts the first filled
        wait_cfg = 2'd2;
        rd(24'h000500, w);  chk("R5 fifth line misses", w, 2);
        rd(24'h000300, w);  chk("R5 third line kept", w, 0);
        rd(24'h000400, w);  chk("R5 fourth line kept", w, 0);
        rd(24'h000508, w);  chk("R5 fifth line held", w, 0);
        rd(24'h000100, w);  chk("R5 first line evicted", w, 2);

        // R4: differing upper tag bit is a different line
        rd(24'h800100, w);  chk("R4 upper tag bit differs", w, 2);
        rd(24'h000100, w);  chk("R4 original line still held", w, 0);

        // R9: changing wait_cfg mid-access has no effect on it
        wait_cfg = 2'd3;
        do_read(24'h900000, 1, 2'd1, 1'b0, w); chk("R9 latched ws kept", w, 3);
        wait_cfg = 2'd2;

        // R8: idle flush, then flush inside a fill
        flush_bufs = 1'b1; idle_cycles(1, b); flush_bufs = 1'b0;
        rd(24'h000100, w);  chk("R8 miss after flush", w, 2);
        wait_cfg = 2'd3;
        do_read(24'h000A00, 1, 2'd3, 1'b1, w); chk("R8 demand still served", w, 3);
        rd(24'h000A00, w);  chk("R8 flushed fill not kept", w, 3);

        // R6: next-line fetch in idle window
        wait_cfg = 2'd2; nextline_en = 1'b1;
        rd(24'h002000, w);  chk("R6 demand miss", w, 2);
        idle_cycles(4, b);  chk("R6 next line fetched", b, 2);
        rd(24'h002010, w);  chk("R6 next line hits", w, 0);
        rd(24'h003010, w);  chk("R6 miss line 0x301", w, 2);
        rd(24'h003000, w);  chk("R6 miss line 0x300", w, 2);
        idle_cycles(4, b);  chk("R6 held next line skipped", b, 0);

        // R7: reads during a background fetch
        rd(24'h004000, w);  chk("R7 demand miss", w, 2);
        idle_cycles(1, b);
        rd(24'h004010, w);  chk("R7 read of fetching line waits", w, 2);
        rd(24'h005000, w);  chk("R7 demand miss", w, 2);
        idle_cycles(1, b);
        rd(24'h007000, w);  chk("R7 other line after fetch", w, 4);

        // R10: feature off, no background access
        nextline_en = 1'b0;
        rd(24'h006000, w);  chk("R10 demand miss", w, 2);
        idle_cycles(4, b);  chk("R10 no background access", b, 0);
        rd(24'h006010, w);  chk("R10 next line misses", w, 2);

        idle_cycles(2, b);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule